// File: doc/BRIEF.md
# Oscillator Settling Wait Sequencer

This block keeps the core in reset, or keeps its clock gated, until an oscillator has had time to settle. It takes over two general 8-bit down-counters, called timer 3 and timer 4 here, and uses them as one fixed wait counter. Timer 3 is the low stage and timer 4 counts timer 3 overflows. The low stage starts at 0xFF and the high stage at 0x07, so one wait lasts 256 × 8 = 2048 low-stage ticks. When the high stage overflows, the wait ends. With the input clock divided by 16 as the tick source, that is 32768 input clocks.

The sequencer runs a wait in two cases. After a power-on or external reset it forces the divide-by-16 enable as the low-stage source. After a stop-mode wake-up it keeps the source that software selected. In that case the divide-by-16 enable drives the count only when the select bits are zero. Otherwise an alternate tick input drives it. Throughout a wait and during stop, the block reports the forced cascade and the preload values to the timer unit, and it masks the timer interrupt requests.

Top module: `osc_wait_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs are: `int_rst_o`=1, `clk_en_o`=0, `cascade_o`=1, `t3_src_force_o`=1, `irq_mask_o`=1, `t3_load_o`=0xFF and `t4_load_o`=0x07.
- R2: In the reset wait, only clock edges with `div16_en_i`=1 count as ticks. `alt_tick_i` and `t3_sel_i` have no effect.
- R3: Release happens at the clock edge of exactly the 2048th tick. At that edge `int_rst_o` goes to 0, `clk_en_o` goes to 1, and `cascade_o` and `t3_src_force_o` go to 0. `int_rst_o` does not rise again without a reset.
- R4: In the run state, `stop_req_i`=1 drives `load_o` to 1 combinationally. After the next edge: `clk_en_o`=0, `cascade_o`=1, `int_rst_o`=0 and `t3_src_force_o`=0. Both counter stages are reloaded.
- R5: In the stop state no ticks are counted, and the clock stays gated until `wake_i` arrives.
- R6: `wake_i` in the stop state starts a wait of 2048 ticks. If `t3_sel_i`=2'b00, the ticks come from `div16_en_i`; any other value selects `alt_tick_i`. The unselected input is ignored. The tick on the wake edge itself does not count.
- R7: `wake_i` is ignored outside the stop state. `stop_req_i` is ignored outside the run state. If `stop_req_i` and `wake_i` arrive together in the run state, the block enters stop and waits for a later wake.
- R8: `irq_mask_o` is 1 exactly when `clk_en_o` is 0.
- R9: Every new wait starts from full preloads. This holds for a second stop after a completed one, and for a reset in the middle of a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_req_i | input | 1 | Stop-mode entry request |
| wake_i | input | 1 | Stop-mode wake-up event |
| div16_en_i | input | 1 | One-cycle enable at clock/16 rate |
| alt_tick_i | input | 1 | Tick of the non-divided source selected by software |
| t3_sel_i | input | 2 | Low-stage source select from software, 2'b00 = divide-by-16 |
| int_rst_o | output | 1 | Internal reset held for the core |
| clk_en_o | output | 1 | Internal clock gate enable |
| irq_mask_o | output | 1 | Masks timer interrupt requests |
| cascade_o | output | 1 | Forces timer 3 overflow as the timer 4 source |
| t3_src_force_o | output | 1 | Forces the divide-by-16 source onto timer 3 |
| load_o | output | 1 | Strobe to load the forced preload values |
| t3_load_o | output | 8 | Forced timer 3 preload value |
| t4_load_o | output | 8 | Forced timer 4 preload value |

## Verification
Two events can land in the same cycle in this block. One is a stop request arriving with a wake event. The other is a wake event arriving with a live tick. The bench drives `stop_req_i` and `wake_i` together in the run state and expects stop to win: the clock stays gated until a later wake. On every wake it also raises both tick inputs in the wake cycle. It then counts ticks only from the next edge on, and demands release at exactly the 2048th, so a tick counted on the wake edge, or during stop, shows up as an early release.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;
  typedef enum logic [1:0] {
    ST_RESET_WAIT = 2'd0,
    ST_RUN        = 2'd1,
    ST_STOP       = 2'd2,
    ST_WAKE_WAIT  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/osc_wait_stage.sv
module osc_wait_stage #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic ovf_o
);
  logic [W-1:0] cnt_q;

  // overflow on the tick after reaching zero: divide by INIT+1
  assign ovf_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= INIT;
    else if (load_i)  cnt_q <= INIT;
    else if (ovf_o)   cnt_q <= INIT;
    else if (tick_i)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/osc_wait_cascade.sv
module osc_wait_cascade #(
  parameter int unsigned W        = 8,
  parameter int unsigned N        = 2,
  parameter logic [N*W-1:0] INIT_VEC = {8'h07, 8'hFF}
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic ovf_o
);
  logic [N:0] chain;
  assign chain[0] = tick_i;

  for (genvar g = 0; g < N; g++) begin : g_stage
    osc_wait_stage #(
      .W    (W),
      .INIT (INIT_VEC[g*W +: W])
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .tick_i (chain[g]),
      .ovf_o  (chain[g+1])
    );
  end

  assign ovf_o = chain[N];
endmodule

// File: rtl/osc_wait_src_mux.sv
module osc_wait_src_mux #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             count_i,
  input  logic             force_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             div16_en_i,
  input  logic             alt_tick_i,
  output logic             tick_o
);
  logic use_div16;
  assign use_div16 = force_i || (sel_i == '0);
  assign tick_o    = count_i && (use_div16 ? div16_en_i : alt_tick_i);
endmodule

// File: rtl/osc_wait_fsm.sv
module osc_wait_fsm
  import osc_wait_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_i,
  input  logic       wake_i,
  input  logic       release_i,
  output seq_state_e state_o,
  output logic       load_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET_WAIT: if (release_i)  state_d = ST_RUN;
      ST_RUN:        if (stop_req_i) state_d = ST_STOP;
      ST_STOP:       if (wake_i)     state_d = ST_WAKE_WAIT;
      ST_WAKE_WAIT:  if (release_i)  state_d = ST_RUN;
      default:                       state_d = ST_RESET_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET_WAIT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign load_o  = (state_q == ST_RUN) && stop_req_i;
endmodule

// File: rtl/osc_wait_seq.sv
module osc_wait_seq
  import osc_wait_pkg::*;
#(
  parameter int unsigned TMR_W   = 8,
  parameter int unsigned SEL_W   = 2,
  parameter logic [TMR_W-1:0] T3_INIT = 8'hFF,
  parameter logic [TMR_W-1:0] T4_INIT = 8'h07
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wake_i,
  input  logic             div16_en_i,
  input  logic             alt_tick_i,
  input  logic [SEL_W-1:0] t3_sel_i,
  output logic             int_rst_o,
  output logic             clk_en_o,
  output logic             irq_mask_o,
  output logic             cascade_o,
  output logic             t3_src_force_o,
  output logic             load_o,
  output logic [TMR_W-1:0] t3_load_o,
  output logic [TMR_W-1:0] t4_load_o
);
  localparam int unsigned NSTG = 2;
  localparam logic [NSTG*TMR_W-1:0] INIT_VEC = {T4_INIT, T3_INIT};

  seq_state_e state;
  logic       counting, forced, tick, release_w, load_w;

  osc_wait_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .wake_i     (wake_i),
    .release_i  (release_w),
    .state_o    (state),
    .load_o     (load_w)
  );

  assign counting = (state == ST_RESET_WAIT) || (state == ST_WAKE_WAIT);
  assign forced   = (state == ST_RESET_WAIT);

  osc_wait_src_mux #(.SEL_W(SEL_W)) u_mux (
    .count_i    (counting),
    .force_i    (forced),
    .sel_i      (t3_sel_i),
    .div16_en_i (div16_en_i),
    .alt_tick_i (alt_tick_i),
    .tick_o     (tick)
  );

  osc_wait_cascade #(
    .W        (TMR_W),
    .N        (NSTG),
    .INIT_VEC (INIT_VEC)
  ) u_casc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .tick_i (tick),
    .ovf_o  (release_w)
  );

  assign int_rst_o      = forced;
  assign clk_en_o       = (state == ST_RUN);
  assign irq_mask_o     = (state != ST_RUN);
  assign cascade_o      = (state != ST_RUN);
  assign t3_src_force_o = forced;
  assign load_o         = load_w;
  assign t3_load_o      = T3_INIT;
  assign t4_load_o      = T4_INIT;
endmodule

// File: rtl/osc_wait_seq_chk.sv
module osc_wait_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_req_i,
  input logic int_rst_o,
  input logic clk_en_o,
  input logic irq_mask_o,
  input logic cascade_o,
  input logic t3_src_force_o,
  input logic load_o
);
  assert_rst_gates_clk_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> !clk_en_o);

  assert_force_only_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t3_src_force_o == int_rst_o);

  assert_release_opens_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_rst_o) |-> (clk_en_o && !cascade_o));

  assert_rst_stays_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_rst_o |=> !int_rst_o);

  assert_stop_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && stop_req_i) |=> (!clk_en_o && cascade_o && !int_rst_o));

  assert_load_in_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> clk_en_o);

  assert_irq_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_o == !clk_en_o);
endmodule

bind osc_wait_seq osc_wait_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stop_req_i     (stop_req_i),
  .int_rst_o      (int_rst_o),
  .clk_en_o       (clk_en_o),
  .irq_mask_o     (irq_mask_o),
  .cascade_o      (cascade_o),
  .t3_src_force_o (t3_src_force_o),
  .load_o         (load_o)
);

// File: tb/osc_wait_seq_tb_top.sv
`timescale 1ns/1ps
module osc_wait_seq_tb_top;
  localparam int WAIT_TICKS = 256 * 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stop_req_i = 1'b0, wake_i = 1'b0, div16_en_i = 1'b0, alt_tick_i = 1'b0;
  logic [1:0] t3_sel_i = 2'b00;
  logic int_rst_o, clk_en_o, irq_mask_o, cascade_o, t3_src_force_o, load_o;
  logic [7:0] t3_load_o, t4_load_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  osc_wait_seq dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic pat(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return (i % 3) == 0;
      2: return (i % 2) == 1;
      default: return 1'b0;
    endcase
  endfunction

  // start at a negedge inside a wait; count effective ticks until release
  task automatic run_wait(input string req, input int dp, input int ap, input bit use_alt,
                          input int inject_at);
    int n = 0;
    bit rel = 0;
    for (int i = 0; i < 20000; i++) begin
      if (clk_en_o) begin rel = 1; break; end
      if (irq_mask_o !== 1'b1) chk("R8", irq_mask_o, 1);
      div16_en_i = pat(dp, i);
      alt_tick_i = pat(ap, i);
      stop_req_i = (i == inject_at);
      wake_i     = (i == inject_at);
      if (use_alt ? alt_tick_i : div16_en_i) n++;
      @(negedge clk_i);
    end
    div16_en_i = 0; alt_tick_i = 0; stop_req_i = 0; wake_i = 0;
    chk(req, rel, 1);
    chk(req, n, WAIT_TICKS);
  endtask

  task automatic check_reset_outputs();
    chk("R1", int_rst_o, 1);
    chk("R1", clk_en_o, 0);
    chk("R1", cascade_o, 1);
    chk("R1", t3_src_force_o, 1);
    chk("R1", irq_mask_o, 1);
    chk("R1", t3_load_o, 8'hFF);
    chk("R1", t4_load_o, 8'h07);
  endtask

  task automatic check_run_outputs(input string req);
    chk(req, int_rst_o, 0);
    chk(req, clk_en_o, 1);
    chk(req, cascade_o, 0);
    chk(req, t3_src_force_o, 0);
    chk("R8", irq_mask_o, 0);
  endtask

  task automatic enter_stop(input bit with_wake);
    stop_req_i = 1; wake_i = with_wake;
    #1 chk("R4", load_o, 1);
    @(negedge clk_i);
    stop_req_i = 0; wake_i = 0;
    chk("R4", clk_en_o, 0);
    chk("R4", cascade_o, 1);
    chk("R4", int_rst_o, 0);
    chk("R4", t3_src_force_o, 0);
    chk("R8", irq_mask_o, 1);
  endtask

  task automatic wake_up();
    wake_i = 1; div16_en_i = 1; alt_tick_i = 1;  // tick on wake edge must not count
    @(negedge clk_i);
    wake_i = 0; div16_en_i = 0; alt_tick_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset_outputs();

    // R2: reset wait counts div16 only, alt and select ignored
    t3_sel_i = 2'b11;
    rst_ni = 1;
    run_wait("R2", 1, 0, 0, -1);
    check_run_outputs("R3");

    // R7: wake in run ignored
    wake_i = 1; @(negedge clk_i); wake_i = 0;
    chk("R7", clk_en_o, 1);
    chk("R7", cascade_o, 0);

    // R7: stop with wake same cycle -> stop stays; R5 no counting in stop
    t3_sel_i = 2'b00;
    enter_stop(1);
    div16_en_i = 1; alt_tick_i = 1;
    repeat (3000) @(negedge clk_i);
    div16_en_i = 0; alt_tick_i = 0;
    chk("R5", clk_en_o, 0);
    chk("R7", cascade_o, 1);
    wake_up();
    run_wait("R6", 0, 0, 0, -1);
    check_run_outputs("R6");
    chk("R3", int_rst_o, 0);

    // R6 / R7 / R9: sweep select values, mid-wait stop and wake ignored
    for (int s = 0; s < 4; s++) begin
      t3_sel_i = s[1:0];
      enter_stop(0);
      wake_up();
      if (s == 0) run_wait("R6", 2, 0, 0, 1000);
      else        run_wait("R6", 0, 2, 1, 1000);
      check_run_outputs("R9");
    end

    // R9: reset in the middle of a wake wait restarts the full reset wait
    t3_sel_i = 2'b00;
    enter_stop(0);
    wake_up();
    div16_en_i = 1;
    repeat (500) @(negedge clk_i);
    div16_en_i = 0;
    rst_ni = 0;
    @(negedge clk_i);
    check_reset_outputs();
    rst_ni = 1;
    run_wait("R9", 0, 1, 0, -1);
    check_run_outputs("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule